// File: doc/BRIEF.md
# Interrupt Pin Swizzle Router

The block turns an interrupt event from one bus function into a request on a legacy interrupt line. The request carries the function identifier and the value of that function's interrupt-pin field. The pin field is 1-based: 1 means the first pin, and 0 means the function has no interrupt. The device number is taken from the identifier. The pin and device number together pick one of four bridge inputs. The chosen input is rotated by the device number, so that devices sharing a pin letter are spread across the lines.

A small table of four routing bytes maps each bridge input to an interrupt number. Software writes the table through an 8-bit register port that sits in the bridge function's configuration space. Each byte resets to a disabled state. The block answers a raise or lower strobe one cycle later with a single-cycle request to the interrupt controller, and the request carries the interrupt number.

Top module: `irq_swizzle_router`

## Requirements
- R1: After reset, both request outputs and `irq_num_o` are 0. Every routing byte holds 0x80 (disabled), so no strobe produces a request until the table is written.
- R2: The device number is `func_id_i[7:3]`, and `func_id_i[2:0]` has no effect. The bridge input is ((pin-1)+(device-1)) mod 4. A `raise_i` strobe in cycle N gives `irq_raise_o`=1 in cycle N+1 for exactly that cycle.
- R3: A `lower_i` strobe uses the same input calculation as a raise. It gives `irq_lower_o`=1 one cycle later, with the same interrupt number that a raise with the same function and pin would carry.
- R4: A pin value of 0, or a pin value above 4, produces no request.
- R5: A routing byte with bit 7 set produces no request for any function that maps to that byte.
- R6: A write with `rt_we_i`=1 to address 0x60+k (k=0..3) loads `rt_wdata_i` into routing byte k, which serves bridge input k. Writes to any other address change nothing.
- R7: On a request, `irq_num_o` equals bits 3:0 of the selected routing byte. Bits 6:4 are ignored. When no request is present, `irq_num_o` is 0.
- R8: When `raise_i` and `lower_i` arrive in the same cycle, only the raise is issued.
- R9: A strobe in the same cycle as a routing write uses the byte's previous value. The new value applies from the next strobe on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_i | input | 1 | Interrupt assert strobe from the function |
| lower_i | input | 1 | Interrupt deassert strobe from the function |
| func_id_i | input | 8 | Device/function identifier, device in bits 7:3 |
| pin_i | input | 8 | Interrupt-pin field of the function, 1-based |
| rt_we_i | input | 1 | Routing byte write enable |
| rt_addr_i | input | 8 | Configuration byte offset of the write |
| rt_wdata_i | input | 8 | Routing byte write data |
| irq_raise_o | output | 1 | Raise request to the interrupt controller |
| irq_lower_o | output | 1 | Lower request to the interrupt controller |
| irq_num_o | output | 4 | Interrupt number carried by the request |

## Verification
The assertions assume that the strobes, the identifier and the pin field carry known values in every clock cycle after reset. They also assume that a request can only follow a strobe seen at the previous edge. The bench changes every input on the falling clock edge, so each value is settled long before the rising edge samples it. It drops each strobe after one cycle, which makes every request traceable to exactly one strobe. The routing table is written only through the normal port, and the bench keeps its own copy of the table to build the expected interrupt numbers.

// File: rtl/irq_swizzle_router.sv
module irq_swizzle_router #(
  parameter int              LINES      = 4,
  parameter int              IRQ_W      = 4,
  parameter logic [7:0]      ROUTE_BASE = 8'h60,
  parameter logic [7:0]      ROUTE_RST  = 8'h80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raise_i,
  input  logic             lower_i,
  input  logic [7:0]       func_id_i,
  input  logic [7:0]       pin_i,
  input  logic             rt_we_i,
  input  logic [7:0]       rt_addr_i,
  input  logic [7:0]       rt_wdata_i,
  output logic             irq_raise_o,
  output logic             irq_lower_o,
  output logic [IRQ_W-1:0] irq_num_o
);

  localparam int         IDX_W     = $clog2(LINES);
  localparam logic [8:0] ROUTE_END = 9'(ROUTE_BASE) + 9'(LINES);

  logic [7:0]       route_q [LINES];
  logic [4:0]       dev;
  logic [IDX_W-1:0] pin_idx, dev_idx, idx, wr_idx;
  logic [7:0]       sel;
  logic             pin_ok, fire, wr_hit;

  assign dev     = func_id_i[7:3];
  assign pin_idx = IDX_W'(pin_i - 8'd1);
  assign dev_idx = IDX_W'(dev - 5'd1);
  assign idx     = pin_idx + dev_idx;
  assign sel     = route_q[idx];
  assign pin_ok  = (pin_i != 8'd0) && ({1'b0, pin_i} <= 9'(LINES));
  assign fire    = pin_ok && !sel[7];

  assign wr_hit  = rt_we_i && (rt_addr_i >= ROUTE_BASE) && ({1'b0, rt_addr_i} < ROUTE_END);
  assign wr_idx  = IDX_W'(rt_addr_i - ROUTE_BASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) route_q[i] <= ROUTE_RST;
    end else if (wr_hit) begin
      route_q[wr_idx] <= rt_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_raise_o <= 1'b0;
      irq_lower_o <= 1'b0;
      irq_num_o   <= '0;
    end else begin
      irq_raise_o <= raise_i && fire;
      irq_lower_o <= lower_i && !raise_i && fire;
      irq_num_o   <= (fire && (raise_i || lower_i)) ? sel[IRQ_W-1:0] : '0;
    end
  end

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_raise_o && irq_lower_o)); // R8

  AST_RAISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_raise_o |-> $past(raise_i)); // R2

  AST_LOWER_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lower_o |-> $past(lower_i && !raise_i)); // R3

  AST_PIN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_raise_o || irq_lower_o) |-> $past(pin_i != 8'd0 && {1'b0, pin_i} <= 9'(LINES))); // R4

  AST_ROUTE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_raise_o || irq_lower_o) |-> !$past(sel[7])); // R5

  AST_IDLE_NUM: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_raise_o || irq_lower_o) |-> (irq_num_o == '0)); // R7

endmodule

// File: tb/irq_swizzle_router_bench.sv
module irq_swizzle_router_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raise_i = 1'b0, lower_i = 1'b0, rt_we_i = 1'b0;
  logic [7:0] func_id_i = 8'h0, pin_i = 8'h0, rt_addr_i = 8'h0, rt_wdata_i = 8'h0;
  logic       irq_raise_o, irq_lower_o;
  logic [3:0] irq_num_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] m [4];

  always #4 clk = ~clk;

  irq_swizzle_router u_irq_swizzle_router (
    .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .lower_i(lower_i),
    .func_id_i(func_id_i), .pin_i(pin_i), .rt_we_i(rt_we_i),
    .rt_addr_i(rt_addr_i), .rt_wdata_i(rt_wdata_i),
    .irq_raise_o(irq_raise_o), .irq_lower_o(irq_lower_o), .irq_num_o(irq_num_o)
  );

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got raise/lower/num=%b/%b/%h expected %b/%b/%h",
               req, act[5], act[4], act[3:0], exp[5], exp[4], exp[3:0]);
    end
  endtask

  function automatic logic [5:0] model(logic r, logic l, logic [7:0] fid, logic [7:0] pin);
    int idx;
    logic [7:0] b;
    if (pin == 0 || pin > 4 || !(r || l)) return 6'b0;
    idx = (int'(pin) + int'(fid[7:3]) + 2) & 3;
    b = m[idx];
    if (b[7]) return 6'b0;
    return {r, l && !r, b[3:0]};
  endfunction

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    rt_we_i = 1'b1; rt_addr_i = a; rt_wdata_i = d;
    @(negedge clk);
    rt_we_i = 1'b0;
    if (a >= 8'h60 && a <= 8'h63) m[a - 8'h60] = d;
  endtask

  task automatic strobe(string req, logic r, logic l, logic [7:0] fid, logic [7:0] pin);
    logic [5:0] exp;
    exp = model(r, l, fid, pin);
    @(negedge clk);
    raise_i = r; lower_i = l; func_id_i = fid; pin_i = pin;
    @(negedge clk);
    raise_i = 1'b0; lower_i = 1'b0;
    check(req, {irq_raise_o, irq_lower_o, irq_num_o}, exp);
    @(negedge clk);
    check(req, {irq_raise_o, irq_lower_o, irq_num_o}, 6'b0);
  endtask

  task automatic t_reset;
    check("R1", {irq_raise_o, irq_lower_o, irq_num_o}, 6'b0);
    for (int p = 1; p <= 4; p++) strobe("R1", 1'b1, 1'b0, 8'h08, 8'(p));
  endtask

  task automatic t_program;
    wr(8'h60, 8'h05); wr(8'h61, 8'h7A); wr(8'h62, 8'h0B); wr(8'h63, 8'h03);
  endtask

  task automatic t_raise_sweep;
    for (int d = 0; d < 6; d++)
      for (int p = 1; p <= 4; p++)
        strobe("R2", 1'b1, 1'b0, 8'((d << 3) | (p & 7)), 8'(p));
  endtask

  task automatic t_func_bits;
    strobe("R2", 1'b1, 1'b0, 8'h17, 8'd2);
    strobe("R2", 1'b1, 1'b0, 8'h10, 8'd2);
  endtask

  task automatic t_lower;
    for (int d = 1; d < 5; d++) strobe("R3", 1'b0, 1'b1, 8'(d << 3), 8'd3);
  endtask

  task automatic t_pin_suppress;
    strobe("R4", 1'b1, 1'b0, 8'h08, 8'd0);
    strobe("R4", 1'b0, 1'b1, 8'h10, 8'd5);
    strobe("R4", 1'b1, 1'b0, 8'h18, 8'hFF);
  endtask

  task automatic t_disabled;
    wr(8'h62, 8'h8B);
    strobe("R5", 1'b1, 1'b0, 8'h08, 8'd3);
    strobe("R5", 1'b0, 1'b1, 8'h10, 8'd2);
    strobe("R5", 1'b1, 1'b0, 8'h08, 8'd1);
    wr(8'h62, 8'h0B);
    strobe("R5", 1'b1, 1'b0, 8'h08, 8'd3);
  endtask

  task automatic t_bad_addr;
    wr(8'h5F, 8'h01); wr(8'h64, 8'h02); wr(8'hE0, 8'h0F);
    for (int p = 1; p <= 4; p++) strobe("R6", 1'b1, 1'b0, 8'h08, 8'(p));
  endtask

  task automatic t_high_bits;
    wr(8'h63, 8'h7E);
    strobe("R7", 1'b1, 1'b0, 8'h08, 8'd4);
  endtask

  task automatic t_both;
    strobe("R8", 1'b1, 1'b1, 8'h08, 8'd1);
    strobe("R8", 1'b1, 1'b1, 8'h20, 8'd2);
  endtask

  task automatic t_collide;
    logic [5:0] exp;
    exp = model(1'b1, 1'b0, 8'h08, 8'd1);
    @(negedge clk);
    raise_i = 1'b1; func_id_i = 8'h08; pin_i = 8'd1;
    rt_we_i = 1'b1; rt_addr_i = 8'h60; rt_wdata_i = 8'h09;
    @(negedge clk);
    raise_i = 1'b0; rt_we_i = 1'b0;
    check("R9", {irq_raise_o, irq_lower_o, irq_num_o}, exp);
    m[0] = 8'h09;
    strobe("R9", 1'b1, 1'b0, 8'h08, 8'd1);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m[i] = 8'h80;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_raise_sweep();
    t_func_bits();
    t_lower();
    t_pin_suppress();
    t_disabled();
    t_bad_addr();
    t_high_bits();
    t_both();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule